// File: doc/BRIEF.md
# Command-Sequenced SPI Master with Slave-Select Hold

This block runs bursts of SPI master transfers from a small bank of command words. A start pulse launches a burst: an internal pointer walks the bank from entry 0 up to a programmable last entry, and each entry decides which slave-select line is driven low, the delay before the first serial clock edge, the clock phase, and whether the select line stays low once its byte has been shifted. The pointer returns to entry 0 when the burst ends.

Each transfer moves one 8-bit byte, MSB first, on a serial clock that is the system clock divided by four. Outgoing bytes arrive on a valid/ready stream: a byte is taken only when `tx_valid` and `tx_ready` are both high in the same cycle, and `tx_ready` is high only while a burst is waiting for its next byte and no received byte is still pending. Received bytes leave on a valid/ready stream: `rx_valid` rises when a transfer ends and stays high, with `rx_data` frozen, until `rx_ready` is sampled high. While a received byte is pending, the block accepts no new outgoing byte. This back-pressure means a byte is never overwritten.

A select line that a command holds stays low across the gap to the next transfer, even across the end of a burst. At the edge that accepts the next byte, the select moves straight to the line that the next command names.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset all `ssl_n` lines are high, `sck` rests at CPOL, and `busy`, `done`, `tx_ready` and `rx_valid` are low.
- R2: A command word holds the select index in bits [1:0], the hold flag in bit 2, the delay enable in bit 3, the delay code in bits [6:4] and the clock phase in bit 7. A start pulse runs entries 0 through `seq_last` in order, and the next burst begins again at entry 0.
- R3: The first `sck` transition comes 4*D system cycles after the edge that accepts the byte. D is 1 when the delay enable is 0, whatever the code holds. D is code+1 (1 to 8) when the delay enable is 1.
- R4: At the edge that accepts a byte, `ssl_n` drives exactly the command's line low and all others high. It holds that value for the whole transfer.
- R5: At the edge where a transfer ends, `ssl_n` returns to all high if the command's hold flag is 0. If the flag is 1, the line stays low.
- R6: A held select line stays low through idle and waiting cycles. At the accepting edge of the next transfer it changes directly to the new command's line, with no all-high cycle in between.
- R7: Each transfer makes 8 `sck` pulses of 4 system cycles each and sends the byte MSB first. With phase 0, `mosi` carries bit 7 from the accepting edge and data is valid at each leading edge. With phase 1, data changes on leading edges and is valid at trailing edges.
- R8: `miso` is sampled at the same edges where `mosi` is valid. At the end of the transfer the byte appears on `rx_data` with `rx_valid` high, and both are held until `rx_ready` is sampled high. `tx_ready` stays low while `rx_valid` is high.
- R9: A byte is accepted only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while idle.
- R10: `busy` rises on the edge after a start pulse and falls on the edge that ends the last transfer of the burst. `done` is high for that one cycle only. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a command entry |
| cfg_addr | input | 2 | Command entry index |
| cfg_wdata | input | 8 | Command word (fields as in R2) |
| seq_we | input | 1 | Write strobe for the last-entry register |
| seq_last_in | input | 2 | Index of the last entry in a burst |
| start | input | 1 | Launches a burst when idle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_ready | output | 1 | Block can take an outgoing byte |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| ssl_n | output | 4 | Active-low slave selects |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two pairs of events can fall in the same cycle. First, the end of a transfer sets the pending received byte and releases or keeps the select line in the same edge. For the last command that edge is also when `busy` falls and `done` pulses. The bench samples all four at the first cycle where `rx_valid` is seen and compares them against the hold flag and the command's position in the burst. Second, a pending received byte collides with the offer of the next outgoing byte. The bench holds `rx_ready` low for zero to two extra cycles while `tx_valid` is high and a start pulse is injected. It then requires `tx_ready` to stay low, `rx_data` to stay frozen, and the held select to persist up to the accepting edge.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int SSL_N = 4;
  localparam int SEL_W = $clog2(SSL_N);
  localparam int DLY_W = 3;

  // command word, MSB first: phase, delay code, delay enable, hold, select
  typedef struct packed {
    logic             cpha;
    logic [DLY_W-1:0] dly;
    logic             dly_en;
    logic             keep;
    logic [SEL_W-1:0] sel;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DELAY = 2'd2,
    ST_SHIFT = 2'd3
  } seq_state_t;

endpackage

// File: rtl/spi_seq_bank.sv
module spi_seq_bank
  import spi_seq_pkg::*;
#(
  parameter int N_CMD = 4,
  localparam int AW = $clog2(N_CMD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cmd_t          wdata,
  input  logic          last_we,
  input  logic [AW-1:0] last_in,
  input  logic [AW-1:0] rd_idx,
  output cmd_t          rd_cmd,
  output logic [AW-1:0] seq_last
);

  cmd_t entry [N_CMD];

  for (genvar e = 0; e < N_CMD; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            entry[e] <= '0;
      else if (we && (waddr == AW'(e)))      entry[e] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seq_last <= '0;
    else if (last_we) seq_last <= last_in;
  end

  assign rd_cmd = entry[rd_idx];

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int N_CMD   = 4,
  parameter int SCK_DIV = 4,
  localparam int AW     = $clog2(N_CMD),
  localparam int DCW    = $clog2(8 * SCK_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tx_valid,
  input  logic             rx_pending,
  input  logic             xfer_end,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cmd_keep,
  input  logic             cmd_dly_en,
  input  logic [DLY_W-1:0] cmd_dly,
  input  logic [AW-1:0]    seq_last,
  output logic [AW-1:0]    ptr,
  output logic             tx_ready,
  output logic             load,
  output logic             run,
  output logic [SSL_N-1:0] ssl_n,
  output logic             busy,
  output logic             done
);

  seq_state_t       state;
  logic [DCW-1:0]   dcnt;
  logic [DCW-1:0]   dly_init;
  logic [3:0]       periods;
  logic             keep_q;
  logic [SSL_N-1:0] sel_hot;

  for (genvar g = 0; g < SSL_N; g++) begin : g_hot
    assign sel_hot[g] = (cmd_sel == SEL_W'(g));
  end

  always_comb begin
    periods  = cmd_dly_en ? ({1'b0, cmd_dly} + 4'd1) : 4'd1;
    dly_init = DCW'(periods) * DCW'(SCK_DIV) - DCW'(1);
  end

  assign tx_ready = (state == ST_WAIT) && !rx_pending;
  assign load     = tx_ready && tx_valid;
  assign run      = (state == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      dcnt   <= '0;
      keep_q <= 1'b0;
      ssl_n  <= '1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_WAIT;
            busy  <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (load) begin
            state  <= ST_DELAY;
            dcnt   <= dly_init;
            keep_q <= cmd_keep;
            ssl_n  <= ~sel_hot;
          end
        end
        ST_DELAY: begin
          if (dcnt == '0) state <= ST_SHIFT;
          else            dcnt  <= dcnt - DCW'(1);
        end
        ST_SHIFT: begin
          if (xfer_end) begin
            if (!keep_q) ssl_n <= '1;
            if (ptr == seq_last) begin
              ptr   <= '0;
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              ptr   <= ptr + AW'(1);
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ssl_n) <= 1);

  assert_select_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY) |=> $stable(ssl_n));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == ST_DELAY) && busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int   DATA_W  = 8,
  parameter int   SCK_DIV = 4,
  parameter logic CPOL    = 1'b0,
  localparam int  HALF    = SCK_DIV / 2,
  localparam int  CW      = $clog2(SCK_DIV),
  localparam int  BW      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cpha_in,
  input  logic              run,
  input  logic              miso,
  input  logic              rx_ready,
  output logic              sck,
  output logic              mosi,
  output logic              xfer_end,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  logic [CW-1:0]     dc;
  logic [BW-1:0]     bi;
  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] rsh;
  logic              cpha_q;
  logic              shift_pt;
  logic              samp_pt;

  assign xfer_end = run && (dc == CW'(SCK_DIV - 1)) && (bi == BW'(DATA_W - 1));
  assign shift_pt = run && (dc == (cpha_q ? CW'(SCK_DIV - 1) : CW'(HALF - 1)));
  assign samp_pt  = run && (dc == (cpha_q ? CW'(HALF) : CW'(0)));
  assign sck      = run ? (CPOL ^ (dc < CW'(HALF))) : CPOL;
  assign mosi     = sreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc     <= '0;
      bi     <= '0;
      sreg   <= '0;
      rsh    <= '0;
      cpha_q <= 1'b0;
    end else if (load) begin
      dc     <= '0;
      bi     <= '0;
      sreg   <= tx_data;
      cpha_q <= cpha_in;
    end else if (run) begin
      dc <= (dc == CW'(SCK_DIV - 1)) ? '0 : dc + CW'(1);
      if (dc == CW'(SCK_DIV - 1)) bi <= bi + BW'(1);
      if (shift_pt) sreg <= {sreg[DATA_W-2:0], 1'b0};
      if (samp_pt)  rsh  <= {rsh[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (xfer_end) begin
      rx_valid <= 1'b1;
      rx_data  <= rsh;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));

  assert_no_load_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !load);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int   N_CMD   = 4,
  parameter int   DATA_W  = 8,
  parameter int   SCK_DIV = 4,
  parameter logic CPOL    = 1'b0,
  localparam int  AW      = $clog2(N_CMD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CMD_W-1:0]  cfg_wdata,
  input  logic              seq_we,
  input  logic [AW-1:0]     seq_last_in,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic [SSL_N-1:0]  ssl_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  cmd_t          cur_cmd;
  logic [AW-1:0] ptr;
  logic [AW-1:0] seq_last;
  logic          load;
  logic          run;
  logic          xfer_end;

  spi_seq_bank #(.N_CMD(N_CMD)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .waddr    (cfg_addr),
    .wdata    (cmd_t'(cfg_wdata)),
    .last_we  (seq_we),
    .last_in  (seq_last_in),
    .rd_idx   (ptr),
    .rd_cmd   (cur_cmd),
    .seq_last (seq_last)
  );

  spi_seq_ctrl #(.N_CMD(N_CMD), .SCK_DIV(SCK_DIV)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tx_valid   (tx_valid),
    .rx_pending (rx_valid),
    .xfer_end   (xfer_end),
    .cmd_sel    (cur_cmd.sel),
    .cmd_keep   (cur_cmd.keep),
    .cmd_dly_en (cur_cmd.dly_en),
    .cmd_dly    (cur_cmd.dly),
    .seq_last   (seq_last),
    .ptr        (ptr),
    .tx_ready   (tx_ready),
    .load       (load),
    .run        (run),
    .ssl_n      (ssl_n),
    .busy       (busy),
    .done       (done)
  );

  spi_seq_shifter #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV), .CPOL(CPOL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .tx_data  (tx_data),
    .cpha_in  (cur_cmd.cpha),
    .run      (run),
    .miso     (miso),
    .rx_ready (rx_ready),
    .sck      (sck),
    .mosi     (mosi),
    .xfer_end (xfer_end),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

endmodule

// File: tb/test_spi_cmd_seq.sv
module test_spi_cmd_seq;

  localparam int   CLK_PERIOD = 10;
  localparam logic POL        = 1'b1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       seq_we = 1'b0;
  logic [1:0] seq_last_in = '0;
  logic       start = 1'b0;
  logic       busy, done;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [3:0] ssl_n;
  logic       sck, mosi, miso;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int held_sel = -1;

  assign miso = mosi;

  spi_cmd_seq #(.CPOL(POL)) i_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .seq_we(seq_we), .seq_last_in(seq_last_in),
    .start(start), .busy(busy), .done(done), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .ssl_n(ssl_n), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] sel_mask(input int s);
    return (s < 0) ? 4'hF : ~(4'b0001 << s);
  endfunction

  task automatic wr_cmd(input int k, input logic [7:0] w);
    cfg_we = 1'b1; cfg_addr = 2'(k); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_xfer(input logic [7:0] cw, input logic [7:0] d,
                         input bit last, input int bp);
    int sel, dper, c0, gap, nb;
    bit keep, cpha, prev;
    logic [7:0] bits;
    sel  = int'(cw[1:0]);
    keep = cw[2];
    cpha = cw[7];
    dper = cw[3] ? int'(cw[6:4]) + 1 : 1;
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    // R6: held select remains right up to the accepting edge
    chk(ssl_n == sel_mask(held_sel), "R6", "select before accept", ssl_n, sel_mask(held_sel));
    c0 = cyc;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(ssl_n == sel_mask(sel), "R4", "select at accept (R2 entry order)", ssl_n, sel_mask(sel));
    if (!cpha) chk(mosi == d[7], "R7", "phase0 MSB set up at select", mosi, d[7]);
    while (sck == POL) @(negedge clk);
    gap = cyc - c0;
    chk(gap == 4 * dper + 1, "R3", "delay to first sck edge", gap, 4 * dper + 1);
    nb = 0; bits = '0; prev = POL;
    while (!rx_valid) begin
      if (sck != prev) begin
        if ((!cpha && sck != POL) || (cpha && sck == POL)) begin
          bits = {bits[6:0], mosi};
          nb++;
        end
        prev = sck;
      end
      @(negedge clk);
    end
    chk(nb == 8, "R7", "sample edge count", nb, 8);
    chk(bits == d, "R7", "mosi MSB first", bits, d);
    chk(rx_data == d, "R8", "received byte", rx_data, d);
    chk(ssl_n == (keep ? sel_mask(sel) : 4'hF), "R5", "select at end",
        ssl_n, keep ? sel_mask(sel) : 4'hF);
    chk(busy == !last, "R10", "busy at transfer end", busy, !last);
    chk(done == last, "R10", "done at transfer end", done, last);
    held_sel = keep ? sel : -1;
    if (last) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", done, 0);
    end
    for (int b = 0; b < bp; b++) begin
      if (b == 0 && !last) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      tx_valid = !last;
      chk(rx_valid && !tx_ready, "R8", "hold with no accept", {rx_valid, tx_ready}, 2);
      chk(rx_data == d, "R8", "rx data frozen", rx_data, d);
    end
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R8", "rx taken", rx_valid, 0);
  endtask

  task automatic run_burst(input int i);
    int last;
    logic [7:0] cw [4];
    last = i % 4;
    for (int k = 0; k < 4; k++) begin
      cw[k] = {1'(((i >> 1) ^ k) & 1), 3'((i + 2 * k) % 8), 1'(((i >> 3) ^ k) & 1),
               1'(((i >> k) ^ k) & 1), 2'((i + k) % 4)};
      wr_cmd(k, cw[k]);
    end
    seq_we = 1'b1; seq_last_in = 2'(last);
    @(negedge clk);
    seq_we = 1'b0;
    chk(busy == 1'b0 && tx_ready == 1'b0, "R9", "idle refuses bytes", {busy, tx_ready}, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    for (int k = 0; k <= last; k++)
      do_xfer(cw[k], 8'((i * 37 + k * 91 + 5) & 255), k == last, (i + k) % 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ssl_n == 4'hF, "R1", "reset selects", ssl_n, 15);
    chk(sck == POL, "R1", "reset sck", sck, POL);
    chk(!busy && !done && !tx_ready && !rx_valid, "R1", "reset status",
        {busy, done, tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) run_burst(i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule